// File: doc/BRIEF.md
# Optical readout event sequencer

This block steps a serial link transmitter through one event frame. While idle it waits for a one-cycle transport request. It then emits two header words and hands the link over to a chain of external data sources. When the chain signals that it has finished, the block emits four words of locally captured line state, then two trailer words. It passes through a single end-of-event cycle and returns to idle.

Every word the block emits is 20 bits wide and leaves on a valid/ready stream. A word is offered with `out_valid` high. It stays on `out_data` unchanged until the cycle in which `out_ready` is also high, and it is transferred in that cycle. The sink may hold `out_ready` low for any number of cycles. Back-pressure only delays the frame and never drops or repeats a word. Header word 0, header word 1 and trailer word 0 come from host-written values presented on plain inputs. The last trailer word packs the event number, eight status bits and a fixed end-of-event marker.

The local data words come from a snapshot of two 17-line input groups. The snapshot is taken on the triggered tick (`capture`), so the words do not show the live inputs at transmit time.

Top module: `readout_seq`

## Requirements
- R1: After reset the sequencer is idle, with `out_valid` and `chain_go` both low.
- R2: A `xport_req` sampled high while idle starts a frame. The first word offered is header 0: `hdr0_byte` in bits 7:0 and zeros in bits 19:8.
- R3: The second word is header 1: `hdr1_word` in bits 15:0 and zeros in bits 19:16.
- R4: Once header 1 is transferred, `chain_go` goes high and stays high until `chain_ret` is sampled high. The next cycle offers local word 0.
- R5: The local words are, in order:
  - word 0: group A lines 15:0;
  - word 1: group A line 16 in bit 0;
  - word 2: group B lines 15:0;
  - word 3: group B line 16 in bit 0.
  All other bits of these words are zero.
- R6: The local words carry the line values registered on the last `capture` pulse, not the live inputs. A `capture` that arrives while a local word is being offered is ignored.
- R7: The seventh word is trailer 0: `trl0_word` in bits 15:0 and zeros in bits 19:16.
- R8: The eighth word is trailer 1 and is laid out as follows:
  - bits 7:0: `evt_num`;
  - bits 15:8: `stat_bits`;
  - bits 16 and 18: 0;
  - bits 17 and 19: 1.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. Each word is transferred exactly once.
- R10: The cycle after trailer 1 is transferred is an end-of-event cycle, with `out_valid` and `chain_go` low. The sequencer is idle in the cycle after that.
- R11: A `xport_req` that arrives while a frame is in progress does not restart or repeat the frame.
- R12: `out_valid` is low while idle, while `chain_go` is high, and in the end-of-event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xport_req | input | 1 | Transport request pulse |
| capture | input | 1 | Triggered-tick snapshot strobe |
| glob_in | input | 17 | Group A line inputs |
| pio_in | input | 17 | Group B line inputs |
| hdr0_byte | input | 8 | Host value for header word 0 |
| hdr1_word | input | 16 | Host value for header word 1 |
| trl0_word | input | 16 | Host value for trailer word 0 |
| evt_num | input | 8 | Event number for trailer word 1 |
| stat_bits | input | 8 | Status bits for trailer word 1 |
| chain_go | output | 1 | Link handed to the data-source chain |
| chain_ret | input | 1 | Chain has finished |
| out_valid | output | 1 | Word on `out_data` is offered |
| out_ready | input | 1 | Sink accepts the offered word |
| out_data | output | 20 | Frame word |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- a word held still under back-pressure;
- no valid word while the chain owns the link;
- the request, chain-return and end-of-event transitions;
- the fixed marker bits of trailer 1;
- a snapshot frozen during the local words;
- no restart of a frame already in progress.

Only the bench scenarios can show that the whole frame comes out in order, with the right field packing and exactly once per word under varied stall patterns. They also show that the local words reflect the captured values and not the live ones.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int WORD_W = 20;
  localparam int HDR0_W = 8;
  localparam int HOST_W = 16;
  localparam int EVT_W  = 8;
  localparam int STAT_W = 8;
  localparam int LO_W   = 16;
  localparam logic [3:0] EOE_MARK = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_CHAIN,
    S_LOC0, S_LOC1, S_LOC2, S_LOC3,
    S_TRL0, S_TRL1, S_EOE
  } seq_state_t;

  function automatic logic is_word_state(input seq_state_t s);
    return !(s == S_IDLE || s == S_CHAIN || s == S_EOE);
  endfunction

  function automatic logic is_local_state(input seq_state_t s);
    return (s == S_LOC0 || s == S_LOC1 || s == S_LOC2 || s == S_LOC3);
  endfunction
endpackage

// File: rtl/rsq_snapshot.sv
module rsq_snapshot #(
  parameter int LINE_W = 17,
  parameter int NGRP   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic                         freeze,
  input  logic [NGRP-1:0][LINE_W-1:0]  lines_in,
  output logic [NGRP-1:0][LINE_W-1:0]  lines_q
);
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (!rst_n)
          lines_q[g] <= '0;
        else if (capture && !freeze)
          lines_q[g] <= lines_in[g];
      end
    end
  endgenerate
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xport_req,
  input  logic       chain_ret,
  input  logic       out_ready,
  output seq_state_t state,
  output logic       word_valid,
  output logic       chain_go
);
  seq_state_t nxt;
  logic fire;

  assign word_valid = is_word_state(state);
  assign chain_go   = (state == S_CHAIN);
  assign fire       = word_valid && out_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (xport_req) nxt = S_HDR0;
      S_HDR0:  if (fire) nxt = S_HDR1;
      S_HDR1:  if (fire) nxt = S_CHAIN;
      S_CHAIN: if (chain_ret) nxt = S_LOC0;
      S_LOC0:  if (fire) nxt = S_LOC1;
      S_LOC1:  if (fire) nxt = S_LOC2;
      S_LOC2:  if (fire) nxt = S_LOC3;
      S_LOC3:  if (fire) nxt = S_TRL0;
      S_TRL0:  if (fire) nxt = S_TRL1;
      S_TRL1:  if (fire) nxt = S_EOE;
      S_EOE:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  // R2
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && xport_req) |=> (state == S_HDR0));

  // R4
  chain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_go && chain_ret) |=> (state == S_LOC0));

  // R10
  eoe_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EOE) |=> (state == S_IDLE));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_HDR0 && xport_req) |=> (state != S_HDR0));
endmodule

// File: rtl/rsq_wordmux.sv
module rsq_wordmux
  import rsq_pkg::*;
#(
  parameter int LINE_W = 17,
  parameter int NGRP   = 2
) (
  input  seq_state_t                   state,
  input  logic [HDR0_W-1:0]            hdr0_byte,
  input  logic [HOST_W-1:0]            hdr1_word,
  input  logic [HOST_W-1:0]            trl0_word,
  input  logic [EVT_W-1:0]             evt_num,
  input  logic [STAT_W-1:0]            stat_bits,
  input  logic [NGRP-1:0][LINE_W-1:0]  snap,
  output logic [WORD_W-1:0]            word
);
  localparam int HI_W = LINE_W - LO_W;
  localparam int NLOC = 2 * NGRP;

  logic [NLOC-1:0][WORD_W-1:0] loc;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_loc
      always_comb begin
        loc[2*g]                 = '0;
        loc[2*g][LO_W-1:0]       = snap[g][LO_W-1:0];
        loc[2*g+1]               = '0;
        loc[2*g+1][HI_W-1:0]     = snap[g][LINE_W-1:LO_W];
      end
    end
  endgenerate

  always_comb begin
    word = '0;
    unique case (state)
      S_HDR0: word[HDR0_W-1:0] = hdr0_byte;
      S_HDR1: word[HOST_W-1:0] = hdr1_word;
      S_LOC0: word = loc[0];
      S_LOC1: word = loc[1];
      S_LOC2: word = loc[2];
      S_LOC3: word = loc[3];
      S_TRL0: word[HOST_W-1:0] = trl0_word;
      S_TRL1: word = {EOE_MARK, stat_bits, evt_num};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import rsq_pkg::*;
#(
  parameter int LINE_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xport_req,
  input  logic              capture,
  input  logic [LINE_W-1:0] glob_in,
  input  logic [LINE_W-1:0] pio_in,
  input  logic [7:0]        hdr0_byte,
  input  logic [15:0]       hdr1_word,
  input  logic [15:0]       trl0_word,
  input  logic [7:0]        evt_num,
  input  logic [7:0]        stat_bits,
  output logic              chain_go,
  input  logic              chain_ret,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [19:0]       out_data
);
  localparam int NGRP = 2;

  seq_state_t                  state;
  logic [NGRP-1:0][LINE_W-1:0] lines_in, snap;
  logic                        freeze;

  assign lines_in[0] = glob_in;
  assign lines_in[1] = pio_in;
  assign freeze      = is_local_state(state);

  rsq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .xport_req(xport_req), .chain_ret(chain_ret),
    .out_ready(out_ready), .state(state), .word_valid(out_valid),
    .chain_go(chain_go)
  );

  rsq_snapshot #(.LINE_W(LINE_W), .NGRP(NGRP)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .freeze(freeze),
    .lines_in(lines_in), .lines_q(snap)
  );

  rsq_wordmux #(.LINE_W(LINE_W), .NGRP(NGRP)) u_mux (
    .state(state), .hdr0_byte(hdr0_byte), .hdr1_word(hdr1_word),
    .trl0_word(trl0_word), .evt_num(evt_num), .stat_bits(stat_bits),
    .snap(snap), .word(out_data)
  );

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R12
  chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_go |-> !out_valid);

  // R8
  trailer_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TRL1) |-> (out_valid && out_data[19:16] == 4'b1010));

  // R6
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && out_valid) |=> $stable(snap));
endmodule

// File: tb/test_readout_seq.sv
module test_readout_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xport_req = 1'b0, capture = 1'b0, chain_ret = 1'b0, out_ready = 1'b1;
  logic [16:0] glob_in = '0, pio_in = '0;
  logic [7:0]  hdr0_byte = '0, evt_num = '0, stat_bits = '0;
  logic [15:0] hdr1_word = '0, trl0_word = '0;
  logic        chain_go, out_valid;
  logic [19:0] out_data;

  int checks = 0, fails = 0;
  logic [19:0] exp_q[$];
  logic        stall_mode = 1'b0;
  logic [7:0]  rcnt = '0;
  logic        held_pend = 1'b0;
  logic [19:0] held_val = '0;

  always #5 clk = ~clk;

  readout_seq i_readout_seq (
    .clk(clk), .rst_n(rst_n), .xport_req(xport_req), .capture(capture),
    .glob_in(glob_in), .pio_in(pio_in), .hdr0_byte(hdr0_byte),
    .hdr1_word(hdr1_word), .trl0_word(trl0_word), .evt_num(evt_num),
    .stat_bits(stat_bits), .chain_go(chain_go), .chain_ret(chain_ret),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rcnt = rcnt + 8'd1;
    out_ready = stall_mode ? (rcnt[1:0] != 2'b01 && rcnt[2:0] != 3'b110) : 1'b1;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_pend)
        chk(out_valid && out_data == held_val, "R9 held word", out_data, held_val);
      held_pend = out_valid && !out_ready;
      held_val  = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R9/R11 unexpected word", out_data, 20'h0);
        else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R2/R3/R5/R7/R8 frame word", out_data, e);
        end
      end
    end
  end

  task automatic run_frame(input logic [16:0] g, input logic [16:0] p,
                           input logic [7:0] ev, input logic [7:0] st, input int chain_wait);
    @(posedge clk); #2;
    glob_in = g; pio_in = p; capture = 1'b1;
    @(posedge clk); #2;
    capture = 1'b0; glob_in = ~g; pio_in = ~p;  // R6 live values differ
    evt_num = ev; stat_bits = st;
    exp_q.push_back({12'h000, hdr0_byte});
    exp_q.push_back({4'h0, hdr1_word});
    exp_q.push_back({4'h0, g[15:0]});
    exp_q.push_back({19'h0, g[16]});
    exp_q.push_back({4'h0, p[15:0]});
    exp_q.push_back({19'h0, p[16]});
    exp_q.push_back({4'h0, trl0_word});
    exp_q.push_back({1'b1, 1'b0, 1'b1, 1'b0, st, ev});
    xport_req = 1'b1;
    @(posedge clk); #2;
    xport_req = 1'b0;
    do @(negedge clk); while (!chain_go);
    chk(exp_q.size() == 6, "R4 chain after two headers", 20'(exp_q.size()), 20'd6);
    chk(!out_valid, "R12 valid low in chain", {19'h0, out_valid}, 20'h0);
    for (int i = 0; i < chain_wait; i++) begin
      @(negedge clk);
      chk(chain_go && !out_valid, "R4 chain held", {18'h0, chain_go, out_valid}, 20'h2);
    end
    @(posedge clk); #2;
    xport_req = 1'b1;                   // R11 request mid-frame
    @(posedge clk); #2;
    xport_req = 1'b0; chain_ret = 1'b1;
    @(posedge clk); #2;
    chain_ret = 1'b0; capture = 1'b1;   // R6 capture during local words
    @(posedge clk); #2;
    capture = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!out_valid && !chain_go, "R10 end-of-event quiet", {18'h0, chain_go, out_valid}, 20'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid, "R11/R12 idle, no restart", {19'h0, out_valid}, 20'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !chain_go, "R1 reset state", {18'h0, chain_go, out_valid}, 20'h0);

    hdr0_byte = 8'hA5; hdr1_word = 16'h1234; trl0_word = 16'hBEEF;
    run_frame(17'h1_8001, 17'h0_7FFE, 8'h01, 8'h03, 0);

    stall_mode = 1'b1;
    hdr0_byte = 8'h3C; hdr1_word = 16'hF00D; trl0_word = 16'h0F0F;
    run_frame(17'h0_FFFF, 17'h1_0000, 8'hFF, 8'h3C, 3);

    hdr0_byte = 8'hFF; hdr1_word = 16'hFFFF; trl0_word = 16'hFFFF;
    run_frame(17'h1_FFFF, 17'h1_FFFF, 8'h80, 8'hFF, 5);

    stall_mode = 1'b0;
    hdr0_byte = 8'h00; hdr1_word = 16'h0000; trl0_word = 16'h0000;
    run_frame(17'h0_0000, 17'h0_0001, 8'h00, 8'h00, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule